// File: doc/BRIEF.md
# Frame Sync Detector with Receive Buffer

This block sits behind an FFSK/MSK demodulator and its bit-clock recovery. It receives one recovered data bit together with a one-cycle strobe per symbol. While the receiver is enabled and not yet locked, it searches the bit stream for a 16-bit frame sync word. Three candidates are tested on every strobe: a first programmable word, a second programmable word, and the bitwise complement of the second word. A hit raises a sync interrupt and records which candidate matched. The block then locks.

Once locked, every following bit is packed MSB first into bytes. Each finished byte is placed in a single holding register and raises a data-ready interrupt. If the host has not read that register by the time the next byte finishes, the new byte replaces the old one and an overrun bit is set. The block has no notion of message length. It keeps decoding until the host clears the enable bit, which also drops the lock and restarts the search from an empty window. The baud rate is set outside the block and is visible here only through the strobe spacing.

The host reaches the block through a small register port. A write takes effect on the clock edge. A read returns data combinationally. Strobing a read of the data register acknowledges the byte.

Top module: `fsync_rx`

## Requirements
- R1: After reset both pattern registers (address 1 and address 2) read 0xC4D7, the control register (address 0, bit 0 = enable) reads 0, the status register (address 3) reads 0, and both interrupt outputs are low.
- R2: While enabled and unlocked, a strobe whose bit completes a 16-bit window equal to pattern A (address 1), pattern B (address 2) or ~pattern B sets the sync flag (status bit 0, mirrored on irq_sync) and sets the locked bit (status bit 3). The window is filled newest bit in the LSB.
- R3: The match source field, status bits [5:4], holds 0 for pattern A, 1 for pattern B and 2 for ~pattern B. When several candidates match at once, A takes precedence over B, and B over ~B.
- R4: While the enable bit is 0, strobes have no effect: no sync is found and no byte is assembled. Clearing enable drops the lock and discards a partial byte.
- R5: After lock, the next 8 strobed bits form one byte, first bit in bit 7. The byte is readable at address 4 in bits [7:0], and data-ready (status bit 1, mirrored on irq_data) is set.
- R6: A read strobe at address 4 clears data-ready and overrun, unless a new byte completes in that same cycle.
- R7: A byte that completes while data-ready is still set replaces the held byte and sets overrun (status bit 2).
- R8: Writing 1 to status bit 0 clears the sync flag. The lock and the match source are kept.
- R9: After the search starts, no match is reported until at least 16 bits have been strobed in.
- R10: Once locked, byte assembly continues over any number of bytes until enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Recovered data bit |
| rx_stb | input | 1 | One-cycle strobe marking rx_bit valid |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe (acknowledges the byte at address 4) |
| host_rdata | output | 16 | Read data for host_addr |
| irq_sync | output | 1 | Sync-detected interrupt |
| irq_data | output | 1 | Data-ready interrupt |

## Verification
The bound checker tests these rules on every cycle:
- the reset preset;
- that no sync flag appears and the lock drops while disabled;
- that data-ready and the lock rise only on a strobe;
- that overrun rises only over a held byte;
- that a read clears the flags when no strobe arrives in the same cycle;
- that the match code stays in range.

Only the bench scenarios can show the following:
- which candidate is reported under the precedence rule;
- that a window of fewer than 16 bits never matches;
- the MSB-first byte values;
- which byte survives an overwrite.

// File: rtl/fsync_rx.sv
module fsync_rx #(
  parameter int                PW     = 16,
  parameter int                BW     = 8,
  parameter int                AW     = 3,
  parameter logic [PW-1:0]     PRESET = 16'hC4D7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  input  logic          rx_stb,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [PW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [PW-1:0] host_rdata,
  output logic          irq_sync,
  output logic          irq_data
);
  localparam int FCW = $clog2(PW + 1);
  localparam int BCW = $clog2(BW);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PATA = AW'(1);
  localparam logic [AW-1:0] A_PATB = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_DATA = AW'(4);

  logic           en, locked, sync_f, rdy_f, ovr_f;
  logic [1:0]     src;
  logic [PW-1:0]  pat_a, pat_b, win;
  logic [FCW-1:0] fill;
  logic [BW-1:0]  asm_q, rx_buf;
  logic [BCW-1:0] bcnt;

  logic [PW-1:0] win_nx;
  logic          full, hit_a, hit_b, hit_n, hit;
  logic          srch_stb, data_stb, byte_done, rd_buf, clr_sync;

  assign win_nx    = {win[PW-2:0], rx_bit};
  assign full      = (fill >= FCW'(PW - 1));
  assign srch_stb  = en && rx_stb && !locked;
  assign data_stb  = en && rx_stb && locked;
  assign hit_a     = full && (win_nx == pat_a);
  assign hit_b     = full && (win_nx == pat_b);
  assign hit_n     = full && (win_nx == ~pat_b);
  assign hit       = srch_stb && (hit_a || hit_b || hit_n);
  assign byte_done = data_stb && (bcnt == BCW'(BW - 1));
  assign rd_buf    = host_rd && (host_addr == A_DATA);
  assign clr_sync  = host_wr && (host_addr == A_STAT) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      pat_a <= PRESET;
      pat_b <= PRESET;
    end else if (host_wr) begin
      case (host_addr)
        A_CTRL:  en    <= host_wdata[0];
        A_PATA:  pat_a <= host_wdata;
        A_PATB:  pat_b <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      win    <= '0;
      fill   <= '0;
      locked <= 1'b0;
      asm_q  <= '0;
      bcnt   <= '0;
    end else if (srch_stb) begin
      win <= win_nx;
      if (!full) fill <= fill + FCW'(1);
      if (hit) begin
        locked <= 1'b1;
        bcnt   <= '0;
      end
    end else if (data_stb) begin
      asm_q <= {asm_q[BW-2:0], rx_bit};
      bcnt  <= byte_done ? '0 : bcnt + BCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_f <= 1'b0;
      src    <= 2'd0;
    end else if (hit) begin
      sync_f <= 1'b1;
      src    <= hit_a ? 2'd0 : (hit_b ? 2'd1 : 2'd2);
    end else if (clr_sync) begin
      sync_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rdy_f  <= 1'b0;
      ovr_f  <= 1'b0;
    end else if (byte_done) begin
      rx_buf <= {asm_q[BW-2:0], rx_bit};
      rdy_f  <= 1'b1;
      ovr_f  <= rdy_f && !rd_buf;
    end else if (rd_buf) begin
      rdy_f  <= 1'b0;
      ovr_f  <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_CTRL:  host_rdata[0] = en;
      A_PATA:  host_rdata = pat_a;
      A_PATB:  host_rdata = pat_b;
      A_STAT:  host_rdata[5:0] = {src, locked, ovr_f, rdy_f, sync_f};
      A_DATA:  host_rdata[BW-1:0] = rx_buf;
      default: ;
    endcase
  end

  assign irq_sync = sync_f;
  assign irq_data = rdy_f;
endmodule

module fsync_rx_chk #(
  parameter int            PW     = 16,
  parameter logic [PW-1:0] PRESET = 16'hC4D7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_stb,
  input logic          en,
  input logic          locked,
  input logic          sync_f,
  input logic          rdy_f,
  input logic          ovr_f,
  input logic [1:0]    src,
  input logic [PW-1:0] pat_a,
  input logic [PW-1:0] pat_b,
  input logic          rd_buf
);
  AST_RESET_PRESET: assert property (@(posedge clk) !rst_n |=> (pat_a == PRESET && pat_b == PRESET && !sync_f && !rdy_f)); // R1
  AST_NO_SYNC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (!en && !sync_f) |=> !sync_f); // R4
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !locked); // R4
  AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> $past(rx_stb)); // R2
  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdy_f) |-> ($past(rx_stb) && $past(locked))); // R5
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_f) |-> $past(rdy_f)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_buf && !rx_stb) |=> (!rdy_f && !ovr_f)); // R6
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) sync_f |-> (src != 2'd3)); // R3
endmodule

bind fsync_rx fsync_rx_chk #(.PW(PW), .PRESET(PRESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .en(en), .locked(locked),
  .sync_f(sync_f), .rdy_f(rdy_f), .ovr_f(ovr_f), .src(src),
  .pat_a(pat_a), .pat_b(pat_b), .rd_buf(rd_buf)
);

// File: tb/fsync_rx_bench.sv
`timescale 1ns/1ps
module fsync_rx_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_bit = 0, rx_stb = 0;
  logic [2:0]  host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        irq_sync, irq_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fsync_rx u_fsync_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_stb(rx_stb),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .irq_sync(irq_sync), .irq_data(irq_data)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit ack, output logic [15:0] d);
    @(negedge clk); host_addr = a; host_rd = ack; #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rx_bit = b; rx_stb = 1;
    @(negedge clk); rx_stb = 0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic restart();
    wr(3'd0, 16'd0); wr(3'd3, 16'd1); wr(3'd0, 16'd1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd1, 0, d); check("R1 pattern A preset", d, 16'hC4D7);
    rd(3'd2, 0, d); check("R1 pattern B preset", d, 16'hC4D7);
    rd(3'd0, 0, d); check("R1 ctrl", d, 16'h0000);
    rd(3'd3, 0, d); check("R1 status", d, 16'h0000);
    check("R1 irqs", {14'd0, irq_sync, irq_data}, 16'h0000);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    send_word(16'hC4D7); send_byte(8'h5A);
    rd(3'd3, 0, d); check("R4 strobes ignored while disabled", d, 16'h0000);
  endtask

  task automatic t_sync_and_byte();
    logic [15:0] d;
    wr(3'd0, 16'd1);
    send_bit(1); send_bit(0); send_bit(1);
    send_word(16'hC4D7);
    rd(3'd3, 0, d); check("R2 R3 preset match, A wins over B", d, 16'h0009);
    check("R2 irq_sync", {15'd0, irq_sync}, 16'd1);
    send_byte(8'hA5);
    rd(3'd3, 0, d); check("R5 data ready set", d & 16'h0002, 16'h0002);
    check("R5 irq_data", {15'd0, irq_data}, 16'd1);
    rd(3'd4, 1, d); check("R5 byte MSB first", d, 16'h00A5);
    rd(3'd3, 0, d); check("R6 read clears ready", d & 16'h0006, 16'h0000);
    wr(3'd3, 16'd1);
    rd(3'd3, 0, d); check("R8 sync flag cleared, lock kept", d, 16'h0008);
  endtask

  task automatic t_sources();
    logic [15:0] d;
    wr(3'd1, 16'h1234); wr(3'd2, 16'h5678); restart();
    send_word(16'h1234);
    rd(3'd3, 0, d); check("R3 source A", d, 16'h0009);
    restart(); send_word(16'h5678);
    rd(3'd3, 0, d); check("R3 source B", d, 16'h0019);
    restart(); send_word(16'hA987);
    rd(3'd3, 0, d); check("R3 source inverse B", d, 16'h0029);
    wr(3'd1, 16'hA987); restart(); send_word(16'hA987);
    rd(3'd3, 0, d); check("R3 A beats inverse B", d, 16'h0009);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    wr(3'd1, 16'h0000); restart();
    for (int i = 0; i < 15; i++) send_bit(0);
    rd(3'd3, 0, d); check("R9 no match under 16 bits", d, 16'h0000);
    send_bit(0);
    rd(3'd3, 0, d); check("R9 match at 16th bit", d, 16'h0009);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    send_byte(8'h3C); send_byte(8'hC3);
    rd(3'd3, 0, d); check("R7 overrun set", d & 16'h0006, 16'h0006);
    rd(3'd4, 1, d); check("R7 newest byte kept", d, 16'h00C3);
    rd(3'd3, 0, d); check("R6 read clears overrun", d & 16'h0006, 16'h0000);
    send_byte(8'h81);
    rd(3'd4, 1, d); check("R10 decoding continues", d, 16'h0081);
  endtask

  task automatic t_disable_midbyte();
    logic [15:0] d;
    send_bit(1); send_bit(1); send_bit(1);
    wr(3'd0, 16'd0);
    rd(3'd3, 0, d); check("R4 disable drops lock", d & 16'h0008, 16'h0000);
    send_byte(8'hFF);
    rd(3'd3, 0, d); check("R4 no byte while disabled", d & 16'h0002, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_sync_and_byte();
    t_sources();
    t_fill();
    t_overrun();
    t_disable_midbyte();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule